// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block translates 32-bit virtual addresses with a coarse segment map. The four most significant address bits pick one of sixteen 256 MB segments. Each segment is set either to linear substitution, where a per-segment 4-bit physical base replaces the top nibble, or to paged translation, where the request is handed on to a separate page-table walker. User-mode accesses are confined to the lower eleven segments. With translation switched off, addresses pass straight through, so boot code can run before any segment is set up.

Requests arrive on a valid/ready stream and results leave on a valid/ready stream, one result per request, in order. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays on the outputs, unchanged, until the consumer takes it with `res_ready`. Three configuration words are written through a plain write port: the segment mode word, the low base word and the high base word. `mmu_en` and `user_mode` are sampled with the request.

Top module: `segmap_xlate`

## Requirements
- R1: After reset, `res_valid` is 0 and `req_ready` is 1. The mode word and both base words reset to zero, so every segment is linear with base 0.
- R2: When `mmu_en` is 0 at acceptance, the result has `res_mapped`=1 and `res_paddr` equal to the virtual address, whatever the segment and whatever `user_mode` is.
- R3: For a linear segment n, `res_paddr` = {base_n, vaddr[27:0]} with `res_mapped`=1. For n < 8, base_n is bits [4n+3:4n] of the low base word. For n >= 8, base_n is bits [4(n-8)+3:4(n-8)] of the high base word.
- R4: When mode bit n is 1, segment n is paged. The result has `res_page`=1 and `res_paddr` equal to the virtual address.
- R5: With `mmu_en`=1 and `user_mode`=1, any access with vaddr[31:28] > 0xA gives `res_fault`=1 and `res_paddr`=0. Address 0xAFFFFFFF is still translated normally.
- R6: In kernel mode (`user_mode`=0), segments 0xB to 0xF never fault. Paged segments still report `res_page` in kernel mode.
- R7: Whenever `res_valid` is 1, exactly one of `res_mapped`, `res_page` and `res_fault` is 1.
- R8: The result for an accepted request appears in `res_valid` on the rising edge that accepts it, and is therefore visible in the cycle after acceptance.
- R9: `req_ready` = !`res_valid` || `res_ready`. While `res_valid` is 1 and `res_ready` is 0, every result output holds its value. Results come out in request order.
- R10: With `cfg_we`=1, `cfg_addr` 0 writes the mode word (bits 15:0 only, bit n for segment n), 1 writes the low base word, 2 writes the high base word, and 3 changes nothing. A write only affects requests accepted after the write edge. A request accepted on the same edge as a write uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_en | input | 1 | Translation enable, sampled with the request |
| user_mode | input | 1 | 1 = user access, 0 = kernel access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address, or pass-on address for paged segments |
| res_mapped | output | 1 | Translation finished |
| res_page | output | 1 | Page lookup needed |
| res_fault | output | 1 | Access not permitted |

## Verification
The bench sweeps all sixteen segments in both privilege modes with a mixed mode word and distinct base nibbles. A design that reads the wrong nibble, or mixes up the low and high base words, returns a wrong top nibble. The fault boundary between 0xAFFFFFFF and 0xB0000000 is tested directly: an off-by-one comparison either faults a legal user address or lets a user access reach segment B. Bursts under random consumer stalls catch results that are dropped, duplicated or changed while stalled. A configuration write on the same edge as a request, a write to the unused word, and set upper mode bits check that the configuration decode neither changes early nor aliases.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  typedef enum logic [1:0] {
    KIND_MAP   = 2'd0,
    KIND_PAGE  = 2'd1,
    KIND_FAULT = 2'd2
  } xlate_kind_e;

  localparam logic [1:0] CFG_SEL_MODE = 2'd0;
  localparam int         CFG_SEL_BASE0 = 1;
endpackage

// File: rtl/segmap_cfg.sv
module segmap_cfg #(
  parameter int SEG_BITS = 4,
  parameter int DATA_W   = 32,
  localparam int NSEG     = 1 << SEG_BITS,
  localparam int BASE_TOT = NSEG * SEG_BITS,
  localparam int NBASE_WD = BASE_TOT / DATA_W,
  localparam int CFG_AW   = $clog2(NBASE_WD + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CFG_AW-1:0]   wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NSEG-1:0]     paged_map,
  output logic [BASE_TOT-1:0] base_map
);
  import segmap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paged_map <= '0;
    end else if (wr_en && wr_sel == CFG_AW'(CFG_SEL_MODE)) begin
      paged_map <= wr_data[NSEG-1:0];
    end
  end

  for (genvar w = 0; w < NBASE_WD; w++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_map[w*DATA_W +: DATA_W] <= '0;
      end else if (wr_en && wr_sel == CFG_AW'(CFG_SEL_BASE0 + w)) begin
        base_map[w*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/segmap_decode.sv
module segmap_decode #(
  parameter int          VA_W     = 32,
  parameter int          SEG_BITS = 4,
  parameter logic [3:0]  USER_TOP = 4'hA,
  localparam int NSEG     = 1 << SEG_BITS,
  localparam int OFF_W    = VA_W - SEG_BITS
) (
  input  logic [VA_W-1:0]          vaddr,
  input  logic                     enable,
  input  logic                     is_user,
  input  logic [NSEG-1:0]          paged_map,
  input  logic [NSEG*SEG_BITS-1:0] base_map,
  output logic [VA_W-1:0]          paddr,
  output segmap_pkg::xlate_kind_e  kind
);
  import segmap_pkg::*;

  logic [SEG_BITS-1:0] seg;
  logic [SEG_BITS-1:0] seg_base;
  logic [OFF_W-1:0]    offset;

  assign seg      = vaddr[VA_W-1 -: SEG_BITS];
  assign offset   = vaddr[OFF_W-1:0];
  assign seg_base = base_map[seg*SEG_BITS +: SEG_BITS];

  always_comb begin
    paddr = vaddr;
    kind  = KIND_MAP;
    if (enable) begin
      if (is_user && seg > SEG_BITS'(USER_TOP)) begin
        paddr = '0;
        kind  = KIND_FAULT;
      end else if (paged_map[seg]) begin
        kind  = KIND_PAGE;
      end else begin
        paddr = {seg_base, offset};
      end
    end
  end
endmodule

// File: rtl/segmap_xlate.sv
module segmap_xlate #(
  parameter int         VA_W     = 32,
  parameter int         SEG_BITS = 4,
  parameter int         DATA_W   = 32,
  parameter logic [3:0] USER_TOP = 4'hA,
  localparam int NSEG   = 1 << SEG_BITS,
  localparam int CFG_AW = $clog2(NSEG * SEG_BITS / DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_en,
  input  logic              user_mode,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [VA_W-1:0]   res_paddr,
  output logic              res_mapped,
  output logic              res_page,
  output logic              res_fault
);
  import segmap_pkg::*;

  logic [NSEG-1:0]          paged_map;
  logic [NSEG*SEG_BITS-1:0] base_map;
  logic [VA_W-1:0]          nxt_paddr;
  xlate_kind_e              nxt_kind;

  segmap_cfg #(.SEG_BITS(SEG_BITS), .DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_addr),
    .wr_data   (cfg_wdata),
    .paged_map (paged_map),
    .base_map  (base_map)
  );

  segmap_decode #(.VA_W(VA_W), .SEG_BITS(SEG_BITS), .USER_TOP(USER_TOP)) u_dec (
    .vaddr     (req_vaddr),
    .enable    (mmu_en),
    .is_user   (user_mode),
    .paged_map (paged_map),
    .base_map  (base_map),
    .paddr     (nxt_paddr),
    .kind      (nxt_kind)
  );

  assign req_ready = !res_valid || res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_paddr  <= '0;
      res_mapped <= 1'b0;
      res_page   <= 1'b0;
      res_fault  <= 1'b0;
    end else if (req_ready) begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_paddr  <= nxt_paddr;
        res_mapped <= (nxt_kind == KIND_MAP);
        res_page   <= (nxt_kind == KIND_PAGE);
        res_fault  <= (nxt_kind == KIND_FAULT);
      end
    end
  end
endmodule

// File: rtl/segmap_xlate_chk.sv
module segmap_xlate_chk #(
  parameter int         VA_W     = 32,
  parameter int         SEG_BITS = 4,
  parameter logic [3:0] USER_TOP = 4'hA,
  localparam int OFF_W = VA_W - SEG_BITS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mmu_en,
  input logic            user_mode,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            res_valid,
  input logic            res_ready,
  input logic [VA_W-1:0] res_paddr,
  input logic            res_mapped,
  input logic            res_page,
  input logic            res_fault
);
  logic accept;
  assign accept = req_valid && req_ready;

  // R7
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_mapped, res_page, res_fault}) == 1);

  // R8
  result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) &&
      $stable(res_mapped) && $stable(res_page) && $stable(res_fault)));

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mmu_en) |=> (res_mapped && res_paddr == $past(req_vaddr)));

  // R5
  user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mmu_en && user_mode && req_vaddr[VA_W-1 -: SEG_BITS] > SEG_BITS'(USER_TOP))
      |=> (res_fault && res_paddr == '0));

  // R6
  kernel_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !user_mode) |=> !res_fault);

  // R3
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(mmu_en && user_mode && req_vaddr[VA_W-1 -: SEG_BITS] > SEG_BITS'(USER_TOP)))
      |=> res_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
endmodule

bind segmap_xlate segmap_xlate_chk #(.VA_W(VA_W), .SEG_BITS(SEG_BITS), .USER_TOP(USER_TOP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mmu_en     (mmu_en),
  .user_mode  (user_mode),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_paddr  (res_paddr),
  .res_mapped (res_mapped),
  .res_page   (res_page),
  .res_fault  (res_fault)
);

// File: tb/segmap_xlate_bench.sv
module segmap_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_en = 1'b0, user_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic        res_valid, res_ready = 1'b1;
  logic [31:0] res_paddr;
  logic        res_mapped, res_page, res_fault;

  int checks = 0, failures = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [15:0] sh_mode = '0;
  logic [31:0] sh_lo = '0, sh_hi = '0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  segmap_xlate u_segmap_xlate (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .user_mode(user_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_mapped(res_mapped), .res_page(res_page), .res_fault(res_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 mapped, 1 page lookup, 2 fault
  function automatic logic [33:0] model(input logic [31:0] va, input logic usr, input logic en);
    logic [3:0] seg, b;
    seg = va[31:28];
    if (!en) return {va, 2'd0};
    if (usr && seg > 4'hA) return {32'h0, 2'd2};
    if (sh_mode[seg]) return {va, 2'd1};
    b = (seg >= 4'd8) ? sh_hi[(seg-8)*4 +: 4] : sh_lo[seg*4 +: 4];
    return {b, va[27:0], 2'd0};
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: sh_mode = d[15:0];
      2'd1: sh_lo = d;
      2'd2: sh_hi = d;
      default: ;
    endcase
  endtask

  task automatic send(input logic [31:0] va, input logic usr, input logic en, input string tag);
    @(negedge clk);
    req_vaddr = va; user_mode = usr; mmu_en = en; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(model(va, usr, en));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    // R8: result visible right after the accepting edge
    check(res_valid === 1'b1, "R8 latency", 64'(res_valid), 64'd1);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results delivered", 64'(exp_q.size()), 64'd0);
  endtask

  // consumer back-pressure
  always @(negedge clk) res_ready = stall_mode ? 1'($urandom % 2) : 1'b1;

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && res_valid && res_ready) begin
        logic [33:0] e;
        logic [1:0]  k;
        string       t;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", 64'(res_paddr), 64'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          k = res_fault ? 2'd2 : (res_page ? 2'd1 : 2'd0);
          // R7: one-hot flags
          check($countones({res_mapped, res_page, res_fault}) == 1, "R7 one-hot",
                64'({res_mapped, res_page, res_fault}), 64'd1);
          check({res_paddr, k} == e, t, 64'({res_paddr, k}), 64'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(res_valid === 1'b0, "R1 res_valid at reset", 64'(res_valid), 64'd0);
    check(req_ready === 1'b1, "R1 req_ready at reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    send(32'h5123_4567, 1'b0, 1'b1, "R1 default linear base 0");
    send(32'hF000_0010, 1'b1, 1'b0, "R2 bypass user high seg");
    send(32'h9ABC_DEF0, 1'b0, 1'b0, "R2 bypass kernel");
    drain();

    cfg_write(2'd1, 32'h1E2D_3C4B);
    cfg_write(2'd2, 32'h5A69_7887);
    cfg_write(2'd0, 32'h0000_2019);
    for (int s = 0; s < 16; s++) begin
      send({4'(s), 28'h0ACE_135}, 1'b0, 1'b1, "R3 R4 R6 kernel sweep");
      send({4'(s), 28'hF00_0D0D}, 1'b1, 1'b1, "R3 R4 R5 user sweep");
    end
    send(32'hAFFF_FFFF, 1'b1, 1'b1, "R5 user top legal");
    send(32'hB000_0000, 1'b1, 1'b1, "R5 user first illegal");
    send(32'hD004_000C, 1'b0, 1'b1, "R6 kernel paged seg D");
    drain();

    stall_mode = 1'b1;
    for (int i = 0; i < 40; i++)
      send($urandom, 1'($urandom % 2), 1'($urandom % 4 != 0), "R9 stalled burst");
    drain();
    stall_mode = 1'b0;

    // R10: write on the same edge as a request uses the old base
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'hFFFF_FFFF;
    req_vaddr = 32'h1000_0040; user_mode = 1'b0; mmu_en = 1'b1; req_valid = 1'b1;
    exp_q.push_back(model(32'h1000_0040, 1'b0, 1'b1));
    tag_q.push_back("R10 same-edge write uses old value");
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    sh_lo = 32'hFFFF_FFFF;
    send(32'h1000_0040, 1'b0, 1'b1, "R10 new value after write");
    cfg_write(2'd3, 32'h0000_FFFF);
    send(32'h2000_0000, 1'b0, 1'b1, "R10 unused word write ignored");
    cfg_write(2'd0, 32'hFFFF_0000);
    send(32'h3000_0008, 1'b0, 1'b1, "R10 upper mode bits ignored");
    send(32'hC000_0008, 1'b0, 1'b1, "R10 upper mode bits ignored hi");
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule